// File: doc/BRIEF.md
# Display RAM Write Address Sequencer

This block turns a stream of display data bytes into write operations on a 2-bit-per-pixel display memory. The memory is organised as 17 banks, and each bank has 96 byte-wide columns. Each byte carries four pixels for four vertically adjacent rows. The block holds a logical column pointer and a logical bank pointer. Commands can load either pointer. After every data byte the block steps the pointers in a row-major (horizontal) order or a column-major (vertical) order.

On its way to the memory, each write passes through a mapping stage. Horizontal mirroring reflects the column, and vertical mirroring reflects the bank. A data-order control chooses whether the least or the most significant bit pair of the incoming byte is the topmost pixel. The last bank holds only part of a byte's rows (65 rows in total), so a per-pixel write enable marks which pixel slots are real.

All outputs are registered. A data strobe in one cycle produces exactly one write in the next cycle. The pointers advance on the same clock edge, and that write uses the address from before the advance.

Top module: `dram_addr_seq`

## Requirements
- R1: After reset, `wr_en`, `load_clamped` are 0 and both logical pointers are 0, so the first data byte is written at column 0, bank 0 when no mirroring is selected.
- R2: A column load above 95 sets the column pointer to 95, and a bank load above 16 sets the bank pointer to 16. `load_clamped` is 1 in the cycle after such a load and 0 after a legal load.
- R3: Each cycle with `byte_vld` = 1 gives `wr_en` = 1 in the following cycle only. That write uses the pointer value held before the advance.
- R4: With `vert_order` = 0, the column pointer increments after each byte. After column 95 it returns to 0 and the bank pointer increments.
- R5: With `vert_order` = 1, the bank pointer increments after each byte. After bank 16 it returns to 0 and the column pointer increments.
- R6: After the byte at column 95, bank 16, both pointers return to column 0, bank 0 in either order.
- R7: `wr_col` is 95 minus the logical column when `flip_cols` = 1, and equals the logical column when `flip_cols` = 0.
- R8: `wr_bank` is 16 minus the logical bank when `flip_banks` = 1, and equals the logical bank when `flip_banks` = 0.
- R9: `wr_data` slot k (bits 2k+1:2k) holds the top-to-bottom k-th pixel. With `msb_first` = 0, slot k = `byte_in`[2k+1:2k]. With `msb_first` = 1, slot k = `byte_in`[7-2k:6-2k], so the bit pairs are reversed but the bits inside each pair keep their order.
- R10: `wr_pix_en` is 4'b0001 (only slot 0) when `wr_bank` is 16, and 4'b1111 otherwise.
- R11: A column or bank load in the same cycle as a data byte still writes that byte at the old pointer. The load then wins over the advance: the loaded axis takes the loaded value and the other axis keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_col_vld | input | 1 | Load logical column pointer |
| ld_col_val | input | 7 | Column value to load |
| ld_bank_vld | input | 1 | Load logical bank pointer |
| ld_bank_val | input | 5 | Bank value to load |
| vert_order | input | 1 | 0: row-major stepping, 1: column-major stepping |
| flip_cols | input | 1 | Reflect column on write |
| flip_banks | input | 1 | Reflect bank on write |
| msb_first | input | 1 | Top pixel taken from bits 7:6 instead of 1:0 |
| byte_vld | input | 1 | Data byte strobe |
| byte_in | input | 8 | Data byte |
| wr_en | output | 1 | Memory write strobe |
| wr_col | output | 7 | Physical column |
| wr_bank | output | 5 | Physical bank |
| wr_data | output | 8 | Reordered pixel data |
| wr_pix_en | output | 4 | Per-pixel-slot write enable |
| load_clamped | output | 1 | Previous cycle's load was out of range |

## Verification
The bench builds the block with its default geometry of 96 columns, 17 banks, four pixels per byte and 65 rows. With these values a complete pass over all 1632 addresses, plus the wrap back to the origin, takes only a few thousand cycles. Two such full passes are run, one in each stepping order. On every byte the mirroring and data-order controls follow different periodic patterns, so every address is checked with several control combinations. Boundary loads (95, 96, 16, the maximum code) and a load coinciding with a data byte are then applied one at a time.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef struct packed {
        logic vert;
        logic flip_x;
        logic flip_y;
        logic msb_first;
    } seq_mode_t;

endpackage

// File: rtl/seq_load_clamp.sv
module seq_load_clamp #(
    parameter int LIMIT = 96,
    parameter int W     = 7
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] clamped,
    output logic         over
);
    localparam logic [W-1:0] MAXV = W'(LIMIT - 1);

    always_comb begin
        over    = (raw > MAXV);
        clamped = over ? MAXV : raw;
    end
endmodule

// File: rtl/seq_ptr_step.sv
module seq_ptr_step #(
    parameter int NUM_COLS  = 96,
    parameter int NUM_BANKS = 17,
    parameter int XW        = 7,
    parameter int YW        = 5
) (
    input  logic [XW-1:0] cur_x,
    input  logic [YW-1:0] cur_y,
    input  logic          vert,
    output logic [XW-1:0] nxt_x,
    output logic [YW-1:0] nxt_y
);
    localparam logic [XW-1:0] X_MAX = XW'(NUM_COLS - 1);
    localparam logic [YW-1:0] Y_MAX = YW'(NUM_BANKS - 1);

    logic x_last;
    logic y_last;

    always_comb begin
        x_last = (cur_x == X_MAX);
        y_last = (cur_y == Y_MAX);
        nxt_x  = cur_x;
        nxt_y  = cur_y;
        if (!vert) begin
            nxt_x = x_last ? '0 : cur_x + 1'b1;
            if (x_last) begin
                nxt_y = y_last ? '0 : cur_y + 1'b1;
            end
        end else begin
            nxt_y = y_last ? '0 : cur_y + 1'b1;
            if (y_last) begin
                nxt_x = x_last ? '0 : cur_x + 1'b1;
            end
        end
    end
endmodule

// File: rtl/seq_phys_map.sv
module seq_phys_map
    import dram_seq_pkg::*;
#(
    parameter int NUM_COLS  = 96,
    parameter int NUM_BANKS = 17,
    parameter int NUM_ROWS  = 65,
    parameter int PIX_BITS  = 2,
    parameter int PIX_PER_B = 4,
    parameter int XW        = 7,
    parameter int YW        = 5
) (
    input  logic [XW-1:0]                   log_x,
    input  logic [YW-1:0]                   log_y,
    input  seq_mode_t                       mode,
    input  logic [PIX_BITS*PIX_PER_B-1:0]   din,
    output logic [XW-1:0]                   phys_x,
    output logic [YW-1:0]                   phys_y,
    output logic [PIX_BITS*PIX_PER_B-1:0]   dout,
    output logic [PIX_PER_B-1:0]            pix_en
);
    localparam logic [XW-1:0] X_MAX     = XW'(NUM_COLS - 1);
    localparam logic [YW-1:0] Y_MAX     = YW'(NUM_BANKS - 1);
    localparam int            LAST_USED = NUM_ROWS - (NUM_BANKS - 1) * PIX_PER_B;

    logic [PIX_PER_B-1:0] last_mask;

    always_comb begin
        phys_x = mode.flip_x ? (X_MAX - log_x) : log_x;
        phys_y = mode.flip_y ? (Y_MAX - log_y) : log_y;
        pix_en = (phys_y == Y_MAX) ? last_mask : '1;
    end

    for (genvar k = 0; k < PIX_PER_B; k++) begin : g_slot
        assign last_mask[k] = (k < LAST_USED);
        assign dout[k*PIX_BITS +: PIX_BITS] = mode.msb_first
            ? din[(PIX_PER_B-1-k)*PIX_BITS +: PIX_BITS]
            : din[k*PIX_BITS +: PIX_BITS];
    end
endmodule

// File: rtl/dram_addr_seq.sv
module dram_addr_seq
    import dram_seq_pkg::*;
#(
    parameter int NUM_COLS  = 96,
    parameter int NUM_BANKS = 17,
    parameter int NUM_ROWS  = 65,
    parameter int PIX_BITS  = 2,
    parameter int PIX_PER_B = 4,
    parameter int XW        = $clog2(NUM_COLS),
    parameter int YW        = $clog2(NUM_BANKS),
    parameter int DW        = PIX_BITS * PIX_PER_B
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_col_vld,
    input  logic [XW-1:0]        ld_col_val,
    input  logic                 ld_bank_vld,
    input  logic [YW-1:0]        ld_bank_val,
    input  logic                 vert_order,
    input  logic                 flip_cols,
    input  logic                 flip_banks,
    input  logic                 msb_first,
    input  logic                 byte_vld,
    input  logic [DW-1:0]        byte_in,
    output logic                 wr_en,
    output logic [XW-1:0]        wr_col,
    output logic [YW-1:0]        wr_bank,
    output logic [DW-1:0]        wr_data,
    output logic [PIX_PER_B-1:0] wr_pix_en,
    output logic                 load_clamped
);
    typedef struct packed {
        logic [XW-1:0]        ptr_x;
        logic [YW-1:0]        ptr_y;
        logic                 we;
        logic [XW-1:0]        col;
        logic [YW-1:0]        bank;
        logic [DW-1:0]        data;
        logic [PIX_PER_B-1:0] en;
        logic                 clamp;
    } seq_state_t;

    seq_state_t st_d, st_q;
    seq_mode_t  mode;

    logic [XW-1:0]        ldx_c, stepx, physx;
    logic [YW-1:0]        ldy_c, stepy, physy;
    logic                 ldx_over, ldy_over;
    logic [DW-1:0]        mapped;
    logic [PIX_PER_B-1:0] map_en;

    assign mode = '{vert: vert_order, flip_x: flip_cols,
                    flip_y: flip_banks, msb_first: msb_first};

    seq_load_clamp #(.LIMIT(NUM_COLS), .W(XW)) i_clamp_x (
        .raw(ld_col_val), .clamped(ldx_c), .over(ldx_over)
    );

    seq_load_clamp #(.LIMIT(NUM_BANKS), .W(YW)) i_clamp_y (
        .raw(ld_bank_val), .clamped(ldy_c), .over(ldy_over)
    );

    seq_ptr_step #(
        .NUM_COLS(NUM_COLS), .NUM_BANKS(NUM_BANKS), .XW(XW), .YW(YW)
    ) i_step (
        .cur_x(st_q.ptr_x), .cur_y(st_q.ptr_y), .vert(vert_order),
        .nxt_x(stepx), .nxt_y(stepy)
    );

    seq_phys_map #(
        .NUM_COLS(NUM_COLS), .NUM_BANKS(NUM_BANKS), .NUM_ROWS(NUM_ROWS),
        .PIX_BITS(PIX_BITS), .PIX_PER_B(PIX_PER_B), .XW(XW), .YW(YW)
    ) i_map (
        .log_x(st_q.ptr_x), .log_y(st_q.ptr_y), .mode(mode), .din(byte_in),
        .phys_x(physx), .phys_y(physy), .dout(mapped), .pix_en(map_en)
    );

    always_comb begin
        st_d       = st_q;
        st_d.we    = byte_vld;
        st_d.clamp = (ld_col_vld && ldx_over) || (ld_bank_vld && ldy_over);
        if (byte_vld) begin
            st_d.col  = physx;
            st_d.bank = physy;
            st_d.data = mapped;
            st_d.en   = map_en;
        end
        if (ld_col_vld || ld_bank_vld) begin
            if (ld_col_vld) begin
                st_d.ptr_x = ldx_c;
            end
            if (ld_bank_vld) begin
                st_d.ptr_y = ldy_c;
            end
        end else if (byte_vld) begin
            st_d.ptr_x = stepx;
            st_d.ptr_y = stepy;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en        = st_q.we;
    assign wr_col       = st_q.col;
    assign wr_bank      = st_q.bank;
    assign wr_data      = st_q.data;
    assign wr_pix_en    = st_q.en;
    assign load_clamped = st_q.clamp;
endmodule

// File: rtl/dram_addr_seq_chk.sv
module dram_addr_seq_chk #(
    parameter int NUM_COLS  = 96,
    parameter int NUM_BANKS = 17,
    parameter int XW        = 7,
    parameter int YW        = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ld_col_vld,
    input logic [XW-1:0] ld_col_val,
    input logic          ld_bank_vld,
    input logic [YW-1:0] ld_bank_val,
    input logic          vert_order,
    input logic          flip_cols,
    input logic          byte_vld,
    input logic          wr_en,
    input logic [XW-1:0] wr_col,
    input logic [YW-1:0] wr_bank,
    input logic          load_clamped,
    input logic [XW-1:0] ptr_x,
    input logic [YW-1:0] ptr_y
);
    localparam logic [XW-1:0] X_MAX = XW'(NUM_COLS - 1);
    localparam logic [YW-1:0] Y_MAX = YW'(NUM_BANKS - 1);

    logic no_load;
    assign no_load = !ld_col_vld && !ld_bank_vld;

    p_clamp_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_col_vld && ld_col_val > X_MAX) |=> load_clamped);

    p_clamp_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_bank_vld && ld_bank_val > Y_MAX) |=> (ptr_y == Y_MAX));

    p_one_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> wr_en);

    p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |=> !wr_en);

    p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_col <= X_MAX && wr_bank <= Y_MAX));

    p_horiz_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && no_load && !vert_order && ptr_x != X_MAX)
        |=> (ptr_x == $past(ptr_x) + 1'b1 && ptr_y == $past(ptr_y)));

    p_vert_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && no_load && vert_order && ptr_y != Y_MAX)
        |=> (ptr_y == $past(ptr_y) + 1'b1 && ptr_x == $past(ptr_x)));

    p_final_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && no_load && ptr_x == X_MAX && ptr_y == Y_MAX)
        |=> (ptr_x == '0 && ptr_y == '0));

    p_mirror_col_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && flip_cols) |=> (wr_col == X_MAX - $past(ptr_x)));

    p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && ld_col_vld && !ld_bank_vld && ld_col_val <= X_MAX)
        |=> (ptr_x == $past(ld_col_val) && ptr_y == $past(ptr_y)));
endmodule

bind dram_addr_seq dram_addr_seq_chk #(
    .NUM_COLS(NUM_COLS), .NUM_BANKS(NUM_BANKS), .XW(XW), .YW(YW)
) i_dram_addr_seq_chk (
    .clk(clk), .rst_n(rst_n),
    .ld_col_vld(ld_col_vld), .ld_col_val(ld_col_val),
    .ld_bank_vld(ld_bank_vld), .ld_bank_val(ld_bank_val),
    .vert_order(vert_order), .flip_cols(flip_cols), .byte_vld(byte_vld),
    .wr_en(wr_en), .wr_col(wr_col), .wr_bank(wr_bank),
    .load_clamped(load_clamped),
    .ptr_x(st_q.ptr_x), .ptr_y(st_q.ptr_y)
);

// File: tb/test_dram_addr_seq.sv
module test_dram_addr_seq;
    localparam int NC = 96;
    localparam int NB = 17;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld_col_vld = 1'b0;
    logic [6:0] ld_col_val = '0;
    logic       ld_bank_vld = 1'b0;
    logic [4:0] ld_bank_val = '0;
    logic       vert_order = 1'b0;
    logic       flip_cols = 1'b0;
    logic       flip_banks = 1'b0;
    logic       msb_first = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_in = '0;
    logic       wr_en;
    logic [6:0] wr_col;
    logic [4:0] wr_bank;
    logic [7:0] wr_data;
    logic [3:0] wr_pix_en;
    logic       load_clamped;

    int checks = 0;
    int fails  = 0;
    int ex = 0;
    int ey = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dram_addr_seq i_dram_addr_seq (
        .clk(clk), .rst_n(rst_n),
        .ld_col_vld(ld_col_vld), .ld_col_val(ld_col_val),
        .ld_bank_vld(ld_bank_vld), .ld_bank_val(ld_bank_val),
        .vert_order(vert_order), .flip_cols(flip_cols),
        .flip_banks(flip_banks), .msb_first(msb_first),
        .byte_vld(byte_vld), .byte_in(byte_in),
        .wr_en(wr_en), .wr_col(wr_col), .wr_bank(wr_bank),
        .wr_data(wr_data), .wr_pix_en(wr_pix_en),
        .load_clamped(load_clamped)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    function automatic logic [7:0] exp_data(input logic [7:0] d, input bit msb);
        logic [7:0] r;
        for (int k = 0; k < 4; k++) begin
            r[2*k +: 2] = msb ? d[6-2*k +: 2] : d[2*k +: 2];
        end
        return r;
    endfunction

    // writes one byte and checks the registered write against the model
    task automatic put_byte(input logic [7:0] d, input bit v, input bit mx,
                            input bit my, input bit msb, input string req);
        int pc, pb;
        @(negedge clk);
        vert_order = v; flip_cols = mx; flip_banks = my; msb_first = msb;
        byte_in = d; byte_vld = 1'b1;
        @(negedge clk);
        byte_vld = 1'b0;
        pc = mx ? (NC - 1 - ex) : ex;
        pb = my ? (NB - 1 - ey) : ey;
        chk(wr_en == 1'b1, {"R3 ", req}, int'(wr_en), 1);
        chk(int'(wr_col) == pc, {"R7 col ", req}, int'(wr_col), pc);
        chk(int'(wr_bank) == pb, {"R8 bank ", req}, int'(wr_bank), pb);
        chk(wr_data == exp_data(d, msb), "R9 data", int'(wr_data), int'(exp_data(d, msb)));
        chk(wr_pix_en == ((pb == NB - 1) ? 4'b0001 : 4'b1111), "R10 pixel enable",
            int'(wr_pix_en), (pb == NB - 1) ? 1 : 15);
        @(negedge clk);
        chk(wr_en == 1'b0, "R3 single pulse", int'(wr_en), 0);
    endtask

    function automatic void model_step(input bit v);
        if (!v) begin
            if (ex == NC - 1) begin ex = 0; ey = (ey == NB - 1) ? 0 : ey + 1; end
            else ex = ex + 1;
        end else begin
            if (ey == NB - 1) begin ey = 0; ex = (ex == NC - 1) ? 0 : ex + 1; end
            else ey = ey + 1;
        end
    endfunction

    task automatic load(input bit lx, input int xv, input bit ly, input int yv,
                        input bit exp_clamp);
        @(negedge clk);
        ld_col_vld = lx; ld_col_val = 7'(xv);
        ld_bank_vld = ly; ld_bank_val = 5'(yv);
        @(negedge clk);
        ld_col_vld = 1'b0; ld_bank_vld = 1'b0;
        chk(load_clamped == exp_clamp, "R2 clamp flag", int'(load_clamped), int'(exp_clamp));
        if (lx) ex = (xv > NC - 1) ? NC - 1 : xv;
        if (ly) ey = (yv > NB - 1) ? NB - 1 : yv;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(wr_en == 1'b0, "R1 reset wr_en", int'(wr_en), 0);
        chk(load_clamped == 1'b0, "R1 reset flag", int'(load_clamped), 0);
        rst_n = 1'b1;
        put_byte(8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, "R1 first write");
        model_step(1'b0);

        // full row-major pass plus wrap
        for (int i = 0; i <= NC * NB; i++) begin
            if (i == NC * NB) begin
                chk(ex == 1 && ey == 0, "R6 model wrap horizontal", ex, 1);
            end
            put_byte(8'(i * 37 + 11), 1'b0, (i % 3) == 0, (i % 5) == 1, i[1],
                     "R4 horizontal");
            model_step(1'b0);
        end

        // final address wrap in row-major order (R6)
        load(1'b1, NC - 1, 1'b1, NB - 1, 1'b0);
        put_byte(8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, "R6 last horizontal");
        model_step(1'b0);
        put_byte(8'hC3, 1'b0, 1'b0, 1'b0, 1'b0, "R6 origin horizontal");
        model_step(1'b0);

        // full column-major pass from origin
        load(1'b1, 0, 1'b1, 0, 1'b0);
        for (int i = 0; i <= NC * NB; i++) begin
            put_byte(8'(i * 53 + 7), 1'b1, (i % 4) == 2, (i % 3) == 1, i[0],
                     "R5 vertical");
            model_step(1'b1);
        end
        load(1'b1, NC - 1, 1'b1, NB - 1, 1'b0);
        put_byte(8'h0F, 1'b1, 1'b0, 1'b0, 1'b1, "R6 last vertical");
        model_step(1'b1);
        put_byte(8'hF0, 1'b1, 1'b0, 1'b0, 1'b1, "R6 origin vertical");
        model_step(1'b1);

        // clamping boundaries (R2)
        load(1'b1, 120, 1'b0, 0, 1'b1);
        put_byte(8'h11, 1'b0, 1'b0, 1'b0, 1'b0, "R2 col clamp");
        model_step(1'b0);
        load(1'b1, 96, 1'b1, 31, 1'b1);
        put_byte(8'h22, 1'b1, 1'b0, 1'b0, 1'b0, "R2 col and bank clamp");
        model_step(1'b1);
        load(1'b1, 95, 1'b1, 16, 1'b0);
        put_byte(8'h33, 1'b0, 1'b1, 1'b1, 1'b0, "R2 legal max load");
        model_step(1'b0);
        load(1'b0, 0, 1'b1, 17, 1'b1);
        put_byte(8'h44, 1'b0, 1'b0, 1'b0, 1'b0, "R2 bank clamp");
        model_step(1'b0);

        // load in the same cycle as a byte (R11)
        load(1'b1, 10, 1'b1, 3, 1'b0);
        @(negedge clk);
        vert_order = 1'b0; flip_cols = 1'b0; flip_banks = 1'b0; msb_first = 1'b0;
        byte_in = 8'h5A; byte_vld = 1'b1;
        ld_col_vld = 1'b1; ld_col_val = 7'd40;
        @(negedge clk);
        byte_vld = 1'b0; ld_col_vld = 1'b0;
        chk(wr_en && wr_col == 7'd10 && wr_bank == 5'd3, "R11 old pointer used",
            int'(wr_col), 10);
        ex = 40;
        put_byte(8'h66, 1'b0, 1'b0, 1'b0, 1'b0, "R11 loaded column kept bank");
        model_step(1'b0);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule